// File: doc/BRIEF.md
# Graphics DRAM Command Decoder with Auto-Precharge Lockout

This block sits on the device side of a two-bank synchronous graphics DRAM. On every rising clock edge it samples the chip select, the three active-low command strobes, the block-function strobe, the bank select and the address bus. It turns them into a command code and keeps a state per bank: idle, open, or closing. It also holds the mode register.

When a write or block write asks for automatic precharge, the block loads a per-bank down-counter. The length of that window depends on the programmed burst length, or on the block-write time, together with the write-recovery and row-precharge times. A command to a bank that is still counting is rejected. So is any other illegal command: a mode write while a bank is not idle, an access before the mode register has ever been written, or a command in the clock right after a mode write.

A rejected command leaves the bank states and the mode register as they were. It raises a one-cycle violation flag. All outputs are registered and change one clock after the command is sampled.

Top module: `sgr_cmd_ctl`

## Requirements
- R1: Commands decode from {row_stb_n, col_stb_n, wen_stb_n, blk_fn}. 0110 is activate (code 1). 1010 is read (2). 1000 is write: code 3 when adr[8] is 0, and write with auto-precharge (code 4) when adr[8] is 1. 1011 is block write: code 5 when adr[8] is 0, and block write with auto-precharge (code 6) when adr[8] is 1. 0100 is precharge (7). 0000 is mode write (8). A command is a no-op (code 0) when sel_n is high, or when the three active-low command strobes are all high, whatever blk_fn is. Every other pattern is "other" (code 9). Codes 0 and 9 have no effect and are never flagged. cmd_o shows the code one clock after the sample.
- R2: While rst is high, and in the cycle after it falls, the outputs are: cmd_o = 0, viol_o = 0, both banks idle, mode_set_o = 0. mode_set_o never falls again after the first accepted mode write.
- R3: Bank states read from bank_st_o[2*i+1:2*i] with the encoding idle = 0, open = 1, closing = 2. An activate to an idle bank opens it. An activate to a bank that is open or closing is flagged.
- R4: A read, write or block write (of any kind) is flagged if no mode write has been accepted since reset, or if the target bank is not open. An accepted plain read, write or block write leaves the bank open.
- R5: An accepted write with auto-precharge issued at edge t, when the burst length is not full page, puts the bank into the closing state. Let N = burst length + T_WR + T_RP. Every command to that bank at edges t+1 through t+N-1 is flagged. The bank reads idle after edge t+N-1, and a command at edge t+N is accepted.
- R6: When the burst-length field is full page, a write with auto-precharge acts as a plain write. The bank stays open and accepts a read on the next clock.
- R7: An accepted block write with auto-precharge gives a lockout of N = T_BPL + T_RP clocks, measured the same way as in R5.
- R8: An accepted precharge to an open bank gives a lockout of T_RP clocks and then leaves the bank idle. A precharge to an idle bank is accepted and changes nothing.
- R9: An accepted mode write stores {bank_sel, adr} into mode_o and sets mode_set_o. A mode write while either bank is not idle is flagged, and mode_o keeps its old value.
- R10: Any command other than codes 0 and 9, sampled in the clock directly after an accepted mode write, is flagged.
- R11: A flagged command changes no bank state and no mode register content; only the countdown already in progress continues. viol_o is high for exactly the one cycle that reports that command. A lockout on one bank does not block commands to the other bank.
- R12: The burst-length field is mode_o[2:0]. 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page, and every other value gives 1. mode_o[3] holds the addressing mode and mode_o[6:4] the CAS latency; both are stored only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low |
| row_stb_n | input | 1 | Row command strobe, active low |
| col_stb_n | input | 1 | Column command strobe, active low |
| wen_stb_n | input | 1 | Write-enable strobe, active low |
| blk_fn | input | 1 | Block-function strobe, high selects block write |
| bank_sel | input | 1 | Target bank |
| adr | input | 11 | Address bus; bit 8 requests auto-precharge |
| cmd_o | output | 4 | Registered command code (R1) |
| viol_o | output | 1 | One-cycle flag for a rejected command |
| bank_st_o | output | 4 | Two bits of state per bank |
| mode_o | output | 12 | Mode register contents {bank, address} |
| mode_set_o | output | 1 | High once a mode write has been accepted |

## Verification
The assertions check, on every cycle, the rules that hold at all times:
- a bank reads closing exactly while its counter is nonzero;
- the counter steps down by one each clock;
- no open or close request reaches a counting bank;
- a rejected mode write leaves mode_o stable;
- a command right after a mode write is flagged;
- accesses before the first mode write are flagged;
- mode_set_o never falls.

Only the bench's scenarios can show the following:
- the exact lockout lengths for different burst lengths and for block writes;
- the full-page exception;
- the independence of the two banks;
- the exact command code for each strobe pattern.

// File: rtl/sgr_cmd_pkg.sv
package sgr_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_ACT   = 4'd1,
        CMD_RD    = 4'd2,
        CMD_WR    = 4'd3,
        CMD_WRAP  = 4'd4,
        CMD_BW    = 4'd5,
        CMD_BWAP  = 4'd6,
        CMD_PRE   = 4'd7,
        CMD_MRS   = 4'd8,
        CMD_OTHER = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_e;

    typedef struct packed {
        logic sel_n;
        logic row_n;
        logic col_n;
        logic wen_n;
        logic blk;
    } strobes_t;

    localparam int MAX_BEATS = 8;

    function automatic int unsigned burst_beats(logic [2:0] f);
        case (f)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic is_full_page(logic [2:0] f);
        return f == 3'b111;
    endfunction

endpackage

// File: rtl/sgr_cmd_decode.sv
module sgr_cmd_decode
    import sgr_cmd_pkg::*;
(
    input  strobes_t stb,
    input  logic     auto_pc,
    output cmd_e     cmd
);

    always_comb begin
        if (stb.sel_n || (stb.row_n && stb.col_n && stb.wen_n)) begin
            cmd = CMD_NOP;
        end else begin
            case ({stb.row_n, stb.col_n, stb.wen_n, stb.blk})
                4'b0110: cmd = CMD_ACT;
                4'b1010: cmd = CMD_RD;
                4'b1000: cmd = auto_pc ? CMD_WRAP : CMD_WR;
                4'b1011: cmd = auto_pc ? CMD_BWAP : CMD_BW;
                4'b0100: cmd = CMD_PRE;
                4'b0000: cmd = CMD_MRS;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sgr_bank_track.sv
module sgr_bank_track
    import sgr_cmd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [CNT_W-1:0] hold_i,
    output bank_e            st_o,
    output logic             busy_o
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_o <= BK_IDLE;
            cnt  <= '0;
        end else if (close_i) begin
            cnt  <= hold_i;
            st_o <= (hold_i != '0) ? BK_CLOSING : BK_IDLE;
        end else if (open_i) begin
            st_o <= BK_OPEN;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) st_o <= BK_IDLE;
        end
    end

    assign busy_o = (cnt != '0);

    // R5: the closing state and a running countdown always go together
    a_r5_closing_tracks_count: assert property (@(posedge clk) disable iff (rst)
        (st_o == BK_CLOSING) == busy_o);

    // R11: the rule logic never forwards a command to a counting bank
    a_r11_no_request_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !(open_i || close_i));

    // R8: the lockout shrinks by exactly one per clock
    a_r8_count_steps_down: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sgr_cmd_ctl.sv
module sgr_cmd_ctl
    import sgr_cmd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int N_BANK = 2,
    parameter int AP_BIT = 8,
    parameter int T_WR   = 2,
    parameter int T_RP   = 3,
    parameter int T_BPL  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sel_n,
    input  logic                          row_stb_n,
    input  logic                          col_stb_n,
    input  logic                          wen_stb_n,
    input  logic                          blk_fn,
    input  logic [((N_BANK > 1) ? $clog2(N_BANK) : 1)-1:0] bank_sel,
    input  logic [ADDR_W-1:0]             adr,
    output logic [3:0]                    cmd_o,
    output logic                          viol_o,
    output logic [2*N_BANK-1:0]           bank_st_o,
    output logic [ADDR_W+((N_BANK > 1) ? $clog2(N_BANK) : 1)-1:0] mode_o,
    output logic                          mode_set_o
);

    localparam int BANK_W  = (N_BANK > 1) ? $clog2(N_BANK) : 1;
    localparam int MODE_W  = ADDR_W + BANK_W;
    localparam int WIN_WR  = MAX_BEATS + T_WR + T_RP;
    localparam int WIN_BW  = T_BPL + T_RP;
    localparam int WIN_MAX = (WIN_WR > WIN_BW) ? WIN_WR : WIN_BW;
    localparam int CNT_W   = $clog2(WIN_MAX + 1);

    cmd_e             cmd;
    cmd_e             cmd_q;
    strobes_t         stb;
    bank_e            st   [N_BANK];
    logic [N_BANK-1:0] busy;
    logic [N_BANK-1:0] open_v;
    logic [N_BANK-1:0] close_v;
    logic [CNT_W-1:0] hold;
    logic             is_real;
    logic             bad;
    logic             accept;
    logic             all_idle;
    logic             mrs_hold;
    logic [MODE_W-1:0] mode_q;
    logic             mode_set;

    assign stb = '{sel_n: sel_n, row_n: row_stb_n, col_n: col_stb_n,
                   wen_n: wen_stb_n, blk: blk_fn};

    sgr_cmd_decode u_decode (
        .stb     (stb),
        .auto_pc (adr[AP_BIT]),
        .cmd     (cmd)
    );

    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < N_BANK; i++) begin
            if (st[i] != BK_IDLE) all_idle = 1'b0;
        end
    end

    // Rule check: a rejected command reaches no bank and no register
    always_comb begin
        is_real = !(cmd == CMD_NOP || cmd == CMD_OTHER);
        bad     = mrs_hold && is_real;
        case (cmd)
            CMD_ACT:
                bad = bad || busy[bank_sel] || (st[bank_sel] != BK_IDLE);
            CMD_RD, CMD_WR, CMD_WRAP, CMD_BW, CMD_BWAP:
                bad = bad || !mode_set || busy[bank_sel] || (st[bank_sel] != BK_OPEN);
            CMD_PRE:
                bad = bad || busy[bank_sel];
            CMD_MRS:
                bad = bad || !all_idle;
            default: ;
        endcase
        accept = is_real && !bad;
    end

    always_comb begin
        case (cmd)
            CMD_WRAP: hold = CNT_W'(burst_beats(mode_q[2:0]) + T_WR + T_RP - 1);
            CMD_BWAP: hold = CNT_W'(T_BPL + T_RP - 1);
            default:  hold = CNT_W'(T_RP - 1);
        endcase
        open_v  = '0;
        close_v = '0;
        for (int i = 0; i < N_BANK; i++) begin
            if (accept && (bank_sel == BANK_W'(i))) begin
                open_v[i]  = (cmd == CMD_ACT);
                close_v[i] = ((cmd == CMD_WRAP) && !is_full_page(mode_q[2:0])) ||
                             (cmd == CMD_BWAP) ||
                             ((cmd == CMD_PRE) && (st[i] == BK_OPEN));
            end
        end
    end

    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        sgr_bank_track #(.CNT_W(CNT_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .open_i  (open_v[g]),
            .close_i (close_v[g]),
            .hold_i  (hold),
            .st_o    (st[g]),
            .busy_o  (busy[g])
        );
        assign bank_st_o[2*g +: 2] = st[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_NOP;
            viol_o   <= 1'b0;
            mrs_hold <= 1'b0;
            mode_q   <= '0;
            mode_set <= 1'b0;
        end else begin
            cmd_q    <= cmd;
            viol_o   <= is_real && bad;
            mrs_hold <= accept && (cmd == CMD_MRS);
            if (accept && (cmd == CMD_MRS)) begin
                mode_q   <= {bank_sel, adr};
                mode_set <= 1'b1;
            end
        end
    end

    assign cmd_o      = cmd_q;
    assign mode_o     = mode_q;
    assign mode_set_o = mode_set;

    // R9: a rejected mode write leaves the register untouched
    a_r9_mode_kept_on_reject: assert property (@(posedge clk) disable iff (rst)
        (viol_o && (cmd_q == CMD_MRS)) |-> $stable(mode_q));

    // R10: the clock after an accepted mode write admits no real command
    a_r10_gap_after_mrs: assert property (@(posedge clk) disable iff (rst)
        ((cmd_q == CMD_MRS) && !viol_o) |=>
            ((cmd_q == CMD_NOP) || (cmd_q == CMD_OTHER) || viol_o));

    // R4: accesses before any mode write are rejected
    a_r4_access_needs_mode: assert property (@(posedge clk) disable iff (rst)
        ((cmd_q inside {CMD_RD, CMD_WR, CMD_WRAP, CMD_BW, CMD_BWAP}) && !$past(mode_set))
            |-> viol_o);

    // R2: the mode-loaded indication is sticky
    a_r2_mode_set_sticky: assert property (@(posedge clk) disable iff (rst)
        !$fell(mode_set));

    // R1: no-ops and unused patterns are never flagged
    a_r1_nop_not_flagged: assert property (@(posedge clk) disable iff (rst)
        ((cmd_q == CMD_NOP) || (cmd_q == CMD_OTHER)) |-> !viol_o);

endmodule

// File: tb/sgr_cmd_ctl_tb.sv
`timescale 1ns/1ps
module sgr_cmd_ctl_tb;

    localparam int TWR = 2;
    localparam int TRP = 3;
    localparam int TBPL = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        rn = 1'b1, cn = 1'b1, wn = 1'b1, bf = 1'b0;
    logic [0:0]  bk = '0;
    logic [10:0] ad = '0;
    logic [3:0]  cmd_o;
    logic        viol_o;
    logic [3:0]  bank_st_o;
    logic [11:0] mode_o;
    logic        mode_set_o;

    int total = 0;
    int fails = 0;
    bit done = 0;

    int ms [2];
    int mc [2];
    int mmode;
    bit mvalid, mhold;
    int ecmd;
    bit eviol;

    always #10 clk = ~clk;

    sgr_cmd_ctl u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .row_stb_n(rn), .col_stb_n(cn),
        .wen_stb_n(wn), .blk_fn(bf), .bank_sel(bk), .adr(ad),
        .cmd_o(cmd_o), .viol_o(viol_o), .bank_st_o(bank_st_o),
        .mode_o(mode_o), .mode_set_o(mode_set_o)
    );

    function automatic int beats(int f);
        if (f == 1) return 2;
        if (f == 2) return 4;
        if (f == 3) return 8;
        if (f == 7) return 0;
        return 1;
    endfunction

    function automatic int classify(bit s, bit r, bit c, bit w, bit d, bit a8);
        if (s || (r && c && w)) return 0;
        case ({r, c, w, d})
            4'b0110: return 1;
            4'b1010: return 2;
            4'b1000: return a8 ? 4 : 3;
            4'b1011: return a8 ? 6 : 5;
            4'b0100: return 7;
            4'b0000: return 8;
            default: return 9;
        endcase
    endfunction

    // Reference model derived from the requirements
    always @(posedge clk) begin
        int k, tb, n;
        bit rc, bad, acc;
        if (rst) begin
            ms[0] = 0; ms[1] = 0; mc[0] = 0; mc[1] = 0;
            mmode = 0; mvalid = 0; mhold = 0; ecmd = 0; eviol = 0;
        end else begin
            k  = classify(sel_n, rn, cn, wn, bf, ad[8]);
            tb = int'(bk);
            rc = !(k == 0 || k == 9);
            bad = mhold && rc;
            case (k)
                1: bad = bad || mc[tb] != 0 || ms[tb] != 0;
                2, 3, 4, 5, 6: bad = bad || !mvalid || mc[tb] != 0 || ms[tb] != 1;
                7: bad = bad || mc[tb] != 0;
                8: bad = bad || ms[0] != 0 || ms[1] != 0;
                default: ;
            endcase
            acc = rc && !bad;
            for (int b = 0; b < 2; b++) begin
                if (mc[b] > 0) begin
                    mc[b]--;
                    if (mc[b] == 0) ms[b] = 0;
                end
            end
            n = 0;
            if (acc) begin
                case (k)
                    1: ms[tb] = 1;
                    4: if (beats(mmode & 7) != 0) n = beats(mmode & 7) + TWR + TRP;
                    6: n = TBPL + TRP;
                    7: if (ms[tb] == 1) n = TRP;
                    8: begin mmode = {int'(bk), int'(ad)}; mmode = int'(bk) * 2048 + int'(ad); mvalid = 1; end
                    default: ;
                endcase
                if (n > 0) begin
                    mc[tb] = n - 1;
                    ms[tb] = (n - 1 > 0) ? 2 : 0;
                end
            end
            mhold = acc && k == 8;
            ecmd  = k;
            eviol = rc && bad;
        end
    end

    task automatic check(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        check("R1 command code", int'(cmd_o), ecmd);
        check("R11 violation flag", int'(viol_o), int'(eviol));
        check("R3 bank0 state", int'(bank_st_o[1:0]), ms[0]);
        check("R3 bank1 state", int'(bank_st_o[3:2]), ms[1]);
        check("R9 mode value", int'(mode_o), mmode);
        check("R2 mode loaded", int'(mode_set_o), int'(mvalid));
    endtask

    // kind: 0 nop, 1 act, 2 rd, 3 wr, 4 wr+ap, 5 bw, 6 bw+ap, 7 pre, 8 mrs, 9 other, 10 deselect
    task automatic step(int kind, int b, int a);
        logic [3:0] p;
        sel_n = (kind == 10);
        case (kind)
            1, 10: p = 4'b0110;
            2: p = 4'b1010;
            3, 4: p = 4'b1000;
            5, 6: p = 4'b1011;
            7: p = 4'b0100;
            8: p = 4'b0000;
            9: p = 4'b0111;
            default: p = 4'b1110;
        endcase
        {rn, cn, wn, bf} = p;
        bk = b[0:0];
        ad = a[10:0];
        if (kind == 3 || kind == 5) ad[8] = 1'b0;
        if (kind == 4 || kind == 6) ad[8] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic ap_window(string tag, int bl_code, int n);
        step(7, 0, 0);
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
        step(8, 0, bl_code);
        step(0, 0, 0);
        step(1, 0, 0);
        step(4, 0, 0);
        check({tag, " closing after auto-precharge write"}, int'(bank_st_o[1:0]), 2);
        for (int k = 1; k < n; k++) begin
            step(1, 0, 0);
            check({tag, " command inside lockout"}, int'(viol_o), 1);
        end
        step(1, 0, 0);
        check({tag, " command at end of lockout"}, int'(viol_o), 0);
        check({tag, " bank reopened"}, int'(bank_st_o[1:0]), 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL R2 watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int kind;
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R2 reset command", int'(cmd_o), 0);
        check("R2 reset banks", int'(bank_st_o), 0);
        rst = 1'b0;
        step(0, 0, 0);
        check("R2 first cycle flag", int'(viol_o), 0);
        check("R2 first cycle mode_set", int'(mode_set_o), 0);

        step(3, 0, 0);
        check("R4 write before mode write", int'(viol_o), 1);
        step(8, 0, 11'h021);
        check("R9 mode stored", int'(mode_o), 12'h021);
        check("R9 mode loaded", int'(mode_set_o), 1);
        step(1, 0, 0);
        check("R10 command after mode write", int'(viol_o), 1);
        check("R10 bank unchanged", int'(bank_st_o[1:0]), 0);
        step(2, 1, 0);
        check("R4 read to idle bank", int'(viol_o), 1);
        step(1, 0, 0);
        check("R3 activate idle bank", int'(bank_st_o[1:0]), 1);
        step(1, 0, 0);
        check("R3 activate open bank", int'(viol_o), 1);
        step(10, 1, 0);
        check("R1 deselect is no-op", int'(cmd_o), 0);
        check("R1 deselect leaves bank1", int'(bank_st_o[3:2]), 0);
        step(9, 0, 0);
        check("R1 other pattern code", int'(cmd_o), 9);
        step(3, 0, 0);
        check("R4 plain write keeps bank open", int'(bank_st_o[1:0]), 1);

        // R5 with burst 2: window 2+2+3 = 7, with bank1 used inside it
        step(4, 0, 0);
        check("R5 closing", int'(bank_st_o[1:0]), 2);
        for (int k = 1; k < 7; k++) begin
            if (k == 1) begin
                step(1, 1, 0);
                check("R11 other bank not blocked", int'(viol_o), 0);
            end else begin
                step(1, 0, 0);
                check("R5 blocked inside window", int'(viol_o), 1);
            end
        end
        check("R5 idle at window end", int'(bank_st_o[1:0]), 0);
        step(1, 0, 0);
        check("R5 accepted after window", int'(viol_o), 0);

        // R7: block write lockout 2+3 = 5 on bank1
        step(6, 1, 0);
        for (int k = 1; k < 5; k++) begin
            step(7, 1, 0);
            check("R7 blocked inside block-write window", int'(viol_o), 1);
        end
        step(7, 1, 0);
        check("R7 accepted after window", int'(viol_o), 0);
        check("R8 precharge of idle bank no effect", int'(bank_st_o[3:2]), 0);

        // R8: precharge lockout of 3
        step(7, 0, 0);
        check("R8 closing after precharge", int'(bank_st_o[1:0]), 2);
        step(1, 1, 0);
        step(8, 0, 11'h005);
        check("R9 mode write with open bank", int'(viol_o), 1);
        check("R9 mode unchanged", int'(mode_o), 12'h021);
        step(1, 0, 0);
        check("R8 activate after precharge window", int'(viol_o), 0);
        step(7, 1, 0);
        step(7, 0, 0);
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);

        // R6: full page
        step(8, 0, 11'h007);
        step(0, 0, 0);
        step(1, 0, 0);
        step(4, 0, 0);
        check("R6 full page stays open", int'(bank_st_o[1:0]), 1);
        step(2, 0, 0);
        check("R6 read right after", int'(viol_o), 0);

        ap_window("R12 burst 8", 11'h003, 13);
        ap_window("R12 reserved code", 11'h004, 6);
        ap_window("R5 burst 4", 11'h012, 9);

        for (int i = 0; i < 3000; i++) begin
            kind = int'($urandom_range(0, 19));
            if (kind > 10) kind = (kind > 15) ? 1 : 7;
            if (kind == 8 && $urandom_range(0, 3) != 0) kind = 0;
            step(kind, int'($urandom_range(0, 1)), int'($urandom_range(0, 2047)));
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule